// File: doc/BRIEF.md
# High-Speed Lane Entry/Exit Sequencer

This block steps one clock lane and one data lane of a serial display transmitter through the low-power to high-speed handshake and back. It does not drive the pads itself. Instead it presents a lane state code for each lane every byte-clock cycle, and the analog front end and serialiser downstream act on those codes. A request input starts a burst, an end-of-data input closes it, and a one-cycle ready strobe tells the byte source that payload may flow.

Every interval in the handshake is taken from three packed timing words made of byte-wide fields, counted in byte-clock cycles (one byte clock is eight bit periods). Software writes each field as the wanted cycle count minus a fixed offset, and the sequencer adds that offset back. The offset is 3 for the data-lane zero interval, 0 for the data-lane trail and 1 for every other field. The clock lane enters high speed first and leaves last, so the data lane always sees a running clock.

The timing words are expected to stay stable while a burst is in flight. A request that arrives while the exit interval is still running is not acted on.

Top module: `lane_hs_sequencer`

## Requirements
- R1: After reset, and whenever idle, both lane outputs carry the stop code 0, and `data_ready` is low. Lane codes: 0 stop (LP-11), 1 request (LP-01), 2 bridge (LP-00), 3 HS-zero, 4 HS-data (on the clock lane, a toggling clock), 5 HS-trail.
- R2: A request seen while idle starts the clock lane at once. It spends clk_timing[7:0]+1 cycles in code 1, then clk_timing2[23:16]+1 cycles in code 2, then clk_timing[15:8]+1 cycles in code 3, then code 4. The data lane holds code 0 for a further clk_timing2[15:8]+1 cycles. Bits 31:24 and 7:0 of clk_timing2 are unused.
- R3: The data lane then spends clk_timing[7:0]+1 cycles in code 1, dat_timing[7:0]+1 cycles in code 2 and dat_timing[15:8]+3 cycles in code 3, then enters code 4.
- R4: `data_ready` is high for exactly the first cycle of data-lane code 4. The data lane stays in code 4 until a cycle in which `data_end` is high, and leaves at the next clock edge. This includes the case where `data_end` is high in that same first cycle.
- R5: After HS-data, the data lane spends dat_timing[23:16] cycles in code 5, with a minimum of one cycle when the field is zero. It then returns to code 0.
- R6: While the data lane is back at code 0, the clock lane stays in code 4 for clk_timing[23:16]+1 cycles, then spends clk_timing[31:24]+1 cycles in code 5, then returns to code 0.
- R7: Both lanes then hold code 0 for an exit interval of dat_timing[31:24]+1 cycles, followed by one idle cycle. With the request held high throughout, the next entry (clock code 1) therefore appears dat_timing[31:24]+2 cycles after clock trail ends.
- R8: A request that is raised and dropped again inside the exit interval starts nothing. Both lanes remain at code 0.
- R9: `data_end` has no effect outside data-lane code 4, whether the sequencer is idle or in an entry phase.
- R10: Whenever the data lane is not at code 0, the clock lane is at code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_req | input | 1 | Request to enter high speed, sampled while idle |
| data_end | input | 1 | Last payload byte is on the lane this cycle |
| dat_timing | input | 4*TW | Data-lane fields: exit, trail, zero, prepare (high to low byte) |
| clk_timing | input | 4*TW | Clock-lane fields: trail, post, zero, low-power request width (high to low byte) |
| clk_timing2 | input | 4*TW | Clock prepare in byte 2, clock pre in byte 1 |
| clk_lane | output | 3 | Clock-lane state code |
| dat_lane | output | 3 | Data-lane state code |
| data_ready | output | 1 | One-cycle strobe on the first HS-data cycle |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the ready strobe and end-of-data. The bench raises `data_end` on the very cycle the strobe appears. It then expects a single HS-data cycle followed directly by trail, with the strobe still seen high in that cycle.

The second pair is the end of the exit interval and a pending request. With the request held high, the bench expects the next entry exactly one idle cycle after exit completes. With a request pulsed only inside exit, it expects the lanes to stay at stop.

// File: rtl/lane_hs_sequencer.sv
module lane_hs_sequencer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_req,
  input  logic          data_end,
  input  logic [4*TW-1:0] dat_timing,
  input  logic [4*TW-1:0] clk_timing,
  input  logic [4*TW-1:0] clk_timing2,
  output logic [2:0]    clk_lane,
  output logic [2:0]    dat_lane,
  output logic          data_ready
);

  localparam int CW = TW + 2;
  localparam logic [2:0] ST_STOP   = 3'd0;
  localparam logic [2:0] ST_REQ    = 3'd1;
  localparam logic [2:0] ST_BRIDGE = 3'd2;
  localparam logic [2:0] ST_ZERO   = 3'd3;
  localparam logic [2:0] ST_DATA   = 3'd4;
  localparam logic [2:0] ST_TRAIL  = 3'd5;

  typedef enum logic [3:0] {
    P_IDLE, P_CLPX, P_CPREP, P_CZERO, P_CPRE,
    P_DLPX, P_DPREP, P_DZERO, P_DDATA, P_DTRAIL,
    P_CPOST, P_CTRAIL, P_EXIT
  } phase_t;

  phase_t phase, nxt;
  logic [CW-1:0] cnt, load;
  logic          in_data;

  wire [TW-1:0] f_exit   = dat_timing[4*TW-1:3*TW];
  wire [TW-1:0] f_trail  = dat_timing[3*TW-1:2*TW];
  wire [TW-1:0] f_zero   = dat_timing[2*TW-1:TW];
  wire [TW-1:0] f_prep   = dat_timing[TW-1:0];
  wire [TW-1:0] f_ctrail = clk_timing[4*TW-1:3*TW];
  wire [TW-1:0] f_cpost  = clk_timing[3*TW-1:2*TW];
  wire [TW-1:0] f_czero  = clk_timing[2*TW-1:TW];
  wire [TW-1:0] f_lpx    = clk_timing[TW-1:0];
  wire [TW-1:0] f_cprep  = clk_timing2[3*TW-1:2*TW];
  wire [TW-1:0] f_cpre   = clk_timing2[2*TW-1:TW];

  function automatic logic [CW-1:0] span(input logic [TW-1:0] f, input logic [CW-1:0] off);
    return CW'(f) + off;
  endfunction

  always_comb begin
    nxt = phase;
    case (phase)
      P_IDLE:  if (hs_req) nxt = P_CLPX;
      P_DDATA: if (data_end) nxt = P_DTRAIL;
      P_EXIT:  if (cnt == '0) nxt = P_IDLE;
      default: if (cnt == '0) nxt = phase_t'(phase + 4'd1);
    endcase
  end

  always_comb begin
    case (nxt)
      P_CLPX:   load = span(f_lpx, CW'(1));
      P_CPREP:  load = span(f_cprep, CW'(1));
      P_CZERO:  load = span(f_czero, CW'(1));
      P_CPRE:   load = span(f_cpre, CW'(1));
      P_DLPX:   load = span(f_lpx, CW'(1));
      P_DPREP:  load = span(f_prep, CW'(1));
      P_DZERO:  load = span(f_zero, CW'(3));
      P_DTRAIL: load = (f_trail == '0) ? CW'(1) : span(f_trail, CW'(0));
      P_CPOST:  load = span(f_cpost, CW'(1));
      P_CTRAIL: load = span(f_ctrail, CW'(1));
      P_EXIT:   load = span(f_exit, CW'(1));
      default:  load = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      cnt     <= '0;
      in_data <= 1'b0;
    end else begin
      phase   <= nxt;
      in_data <= (phase == P_DDATA);
      if (nxt != phase)     cnt <= load - CW'(1);
      else if (cnt != '0)   cnt <= cnt - CW'(1);
    end
  end

  always_comb begin
    clk_lane = ST_DATA;
    dat_lane = ST_STOP;
    case (phase)
      P_IDLE, P_EXIT: clk_lane = ST_STOP;
      P_CLPX:   clk_lane = ST_REQ;
      P_CPREP:  clk_lane = ST_BRIDGE;
      P_CZERO:  clk_lane = ST_ZERO;
      P_DLPX:   dat_lane = ST_REQ;
      P_DPREP:  dat_lane = ST_BRIDGE;
      P_DZERO:  dat_lane = ST_ZERO;
      P_DDATA:  dat_lane = ST_DATA;
      P_DTRAIL: dat_lane = ST_TRAIL;
      P_CTRAIL: clk_lane = ST_TRAIL;
      default: ;
    endcase
  end

  assign data_ready = (phase == P_DDATA) && !in_data;

  // R4
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);

  // R5
  data_to_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lane == ST_DATA) |=> (dat_lane == ST_DATA || dat_lane == ST_TRAIL));

  // R8
  exit_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_EXIT && hs_req) |=> (phase == P_EXIT || phase == P_IDLE));

  // R10
  clock_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lane != ST_STOP) |-> (clk_lane == ST_DATA));

  // R9
  end_outside_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_end && phase != P_DDATA && phase != P_IDLE && phase != P_DTRAIL) |=> (dat_lane != ST_TRAIL || $past(dat_lane) == ST_TRAIL));

endmodule

// File: tb/lane_hs_sequencer_tb.sv
module lane_hs_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [95:0] VEC [NV] = '{
    {32'h02030401, 32'h02030501, 32'hAA0102BB},
    {32'h00000000, 32'h00000000, 32'hFF0000FF},
    {32'h0A071405, 32'h06091E04, 32'h00030800},
    {32'h00010100, 32'h00000002, 32'h00000000}
  };
  localparam int NDATA [NV] = '{4, 1, 12, 2};
  localparam bit EARLY [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 0, rst_n = 0, hs_req = 0, data_end = 0;
  logic [31:0] dat_timing = '0, clk_timing = '0, clk_timing2 = '0;
  logic [2:0] clk_lane, dat_lane;
  logic data_ready;
  int checks = 0, fails = 0;

  lane_hs_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .data_end(data_end),
    .dat_timing(dat_timing), .clk_timing(clk_timing), .clk_timing2(clk_timing2),
    .clk_lane(clk_lane), .dat_lane(dat_lane), .data_ready(data_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fld(input logic [31:0] w, input int b);
    return int'(w[b*8 +: 8]);
  endfunction

  task automatic seg(input logic [2:0] ck, input logic [2:0] dl, input int len,
                     input string tag, input bit endv);
    int bad = 0;
    logic [2:0] ack = ck, adl = dl;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      data_end = endv;
      if ((clk_lane !== ck || dat_lane !== dl) && bad == 0) begin
        ack = clk_lane; adl = dat_lane; bad = 1;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: lanes clk=%0d dat=%0d, expected clk=%0d dat=%0d for %0d cycles",
               tag, ack, adl, ck, dl, len);
    end
  endtask

  task automatic run_seq(input int v, input bit keep_req, input bit endv);
    int bad = 0;
    logic [2:0] ack = 0, adl = 0;
    logic ardy = 0;
    seg(3'd1, 3'd0, fld(clk_timing, 0) + 1, "R2 clock request", endv);
    seg(3'd2, 3'd0, fld(clk_timing2, 2) + 1, "R2 clock bridge", endv);
    seg(3'd3, 3'd0, fld(clk_timing, 1) + 1, "R2 clock zero", endv);
    seg(3'd4, 3'd0, fld(clk_timing2, 1) + 1, "R2 clock pre", endv);
    seg(3'd4, 3'd1, fld(clk_timing, 0) + 1, "R3 data request", endv);
    seg(3'd4, 3'd2, fld(dat_timing, 0) + 1, "R3 data bridge", endv);
    seg(3'd4, 3'd3, fld(dat_timing, 1) + 3, endv ? "R9 data zero with early end" : "R3 data zero", endv);
    for (int i = 0; i < NDATA[v]; i++) begin
      @(negedge clk);
      if ((clk_lane !== 3'd4 || dat_lane !== 3'd4 || data_ready !== (i == 0)) && bad == 0) begin
        bad = 1; ack = clk_lane; adl = dat_lane; ardy = data_ready;
      end
      data_end = (i == NDATA[v] - 1);
      if (!keep_req) hs_req = 0;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R4 data phase: clk=%0d dat=%0d ready=%0b, expected clk=4 dat=4 ready=1 only first",
               ack, adl, ardy);
    end
    seg(3'd4, 3'd5, (fld(dat_timing, 2) == 0) ? 1 : fld(dat_timing, 2), "R5 data trail", 1'b0);
    seg(3'd4, 3'd0, fld(clk_timing, 2) + 1, "R6 clock post", 1'b0);
    seg(3'd5, 3'd0, fld(clk_timing, 3) + 1, "R6 clock trail", 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R7 watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (clk_lane !== 3'd0 || dat_lane !== 3'd0 || data_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: clk=%0d dat=%0d ready=%0b, expected 0 0 0", clk_lane, dat_lane, data_ready);
    end
    rst_n = 1;
    @(negedge clk);
    data_end = 1;
    seg(3'd0, 3'd0, 6, "R9 end while idle", 1'b1);
    data_end = 0;

    for (int v = 0; v < NV; v++) begin
      {dat_timing, clk_timing, clk_timing2} = VEC[v];
      @(negedge clk);
      hs_req = 1;
      run_seq(v, 1'b1, EARLY[v]);
      seg(3'd0, 3'd0, fld(dat_timing, 3) + 2, "R7 exit then restart", 1'b0);
      run_seq(v, 1'b0, 1'b0);
      seg(3'd0, 3'd0, fld(dat_timing, 3) + 12, "R1 idle after exit", 1'b0);
    end

    {dat_timing, clk_timing, clk_timing2} = VEC[2];
    @(negedge clk);
    hs_req = 1;
    run_seq(2, 1'b0, 1'b0);
    for (int i = 0; i < fld(dat_timing, 3) + 1; i++) begin
      @(negedge clk);
      hs_req = (i != fld(dat_timing, 3));
    end
    seg(3'd0, 3'd0, 20, "R8 request inside exit", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule